// File: doc/BRIEF.md
# Vector Absolute-Difference Accumulate-Long Unit

This unit executes one family of widening vector instructions. Each 32-bit instruction word chooses an element size, a signed or unsigned interpretation, and whether the lower or upper half of each wide lane is used. For every wide lane of the vector, the unit takes one narrow element from each of the two source vectors, using the same half for both. It extends each element to the wide width, forms their absolute difference, and adds the matching lane of the accumulator vector. The sum wraps modulo the wide width.

A start strobe launches one operation. The full-width result is registered, and a valid flag pulses for one cycle after the strobe. An instruction word that does not match the family, or that uses the reserved size code, raises an illegal flag for one cycle instead. Each lane reads all of its operands from its own wide column, so the caller may write the result back over the accumulator register without keeping a copy. The register-number fields of the word serve only the caller's register file.

Top module: `abd_acc_long`

## Requirements
- R1: A word is accepted only when bits[31:24]=8'b01000101, bit[21]=0 and bits[15:12]=4'b1100. Any other word pulses `illegal` one cycle after `start`. In that case `valid` stays low and `result` keeps its previous value.
- R2: Bits[23:22] set the wide lane width: 2'b01 gives 16 bits, 2'b10 gives 32 bits and 2'b11 gives 64 bits. Narrow elements are half the lane width. Lane k occupies bits [k*W +: W] of every vector.
- R3: A size code of 2'b00 is reserved. It pulses `illegal`, keeps `valid` low and leaves `result` unchanged.
- R4: Bit[10]=0 takes the low half of each wide lane, and bit[10]=1 takes the high half. Both sources use the same half.
- R5: Bit[11]=0 sign-extends the selected narrow elements. Bit[11]=1 zero-extends them.
- R6: Each lane of `result` equals |ext(a) - ext(b)| + acc lane, taken modulo 2^W.
- R7: `valid` (or `illegal`) is high in exactly the one cycle after a clock edge at which `start` was sampled high, and is low otherwise.
- R8: When `start` is low, `result` holds its value.
- R9: The fields bits[20:16], bits[9:5] and bits[4:0] have no effect on `result`, `valid` or `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation |
| insn | input | 32 | Instruction word |
| src_a | input | VLEN | First source vector |
| src_b | input | VLEN | Second source vector |
| acc | input | VLEN | Accumulator vector |
| result | output | VLEN | Registered result vector |
| valid | output | 1 | One-cycle result strobe |
| illegal | output | 1 | One-cycle rejection strobe |

## Verification
The corners that are hardest to reach are the extreme signed pairs. One is the most negative narrow value against the most positive, which gives a difference of 2^N-1. The other is an accumulator lane that is all ones, where the add must wrap. Random data almost never produces either, so the bench builds these vectors deliberately for every size and both halves. Alongside them it sweeps every size, sign and half combination with random data and random register fields.

// File: rtl/abd_acc_long.sv
module abd_acc_long #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [VLEN-1:0] acc,
  output logic [VLEN-1:0] result,
  output logic            valid,
  output logic            illegal
);
  localparam int NSIZE = 3;

  logic [1:0] sz;
  logic       uns, top, legal;
  logic [VLEN-1:0] res_sz [NSIZE];

  assign sz    = insn[23:22];
  assign uns   = insn[11];
  assign top   = insn[10];
  assign legal = (insn[31:24] == 8'b01000101) && !insn[21] &&
                 (insn[15:12] == 4'b1100) && (sz != 2'b00);

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W = 16 << g;
    localparam int N = W / 2;
    localparam int LANES = VLEN / W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [N-1:0] na, nb;
      logic [W-1:0] ea, eb, diff, mag;
      assign na   = top ? src_a[l*W+N +: N] : src_a[l*W +: N];
      assign nb   = top ? src_b[l*W+N +: N] : src_b[l*W +: N];
      assign ea   = {{N{!uns & na[N-1]}}, na};
      assign eb   = {{N{!uns & nb[N-1]}}, nb};
      assign diff = ea - eb;
      assign mag  = diff[W-1] ? -diff : diff;
      assign res_sz[g][l*W +: W] = mag + acc[l*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      valid   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      valid   <= start && legal;
      illegal <= start && !legal;
      if (start && legal) result <= res_sz[sz - 2'd1];
    end
  end

  a_r7_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || illegal) |-> $past(start));
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid, illegal}));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  a_r3_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
    (start && insn[23:22] == 2'b00) |=> (illegal && !valid && $stable(result)));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start) |=> !valid);
endmodule

// File: tb/abd_acc_long_test.sv
`timescale 1ns/1ps
module abd_acc_long_test;
  localparam int VL = 128;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] insn = 0;
  logic [VL-1:0] a = 0, b = 0, c = 0;
  logic [VL-1:0] result;
  logic valid, illegal;
  int checks = 0, fails = 0;

  abd_acc_long #(.VLEN(VL)) uut (.clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .src_a(a), .src_b(b), .acc(c), .result(result), .valid(valid), .illegal(illegal));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(logic u, logic t, logic [1:0] sz);
    return {8'b01000101, sz, 1'b0, 5'($urandom), 4'b1100, u, t, 5'($urandom), 5'($urandom)};
  endfunction

  function automatic logic [VL-1:0] model(logic u, logic t, logic [1:0] sz,
                                          logic [VL-1:0] va, logic [VL-1:0] vb, logic [VL-1:0] vc);
    int w = 8 << sz;
    int n = w / 2;
    logic [VL-1:0] out = '0;
    logic [VL-1:0] wmask = (VL'(1) << w) - 1;
    logic [VL-1:0] nmask = (VL'(1) << n) - 1;
    for (int k = 0; k < VL / w; k++) begin
      logic [VL-1:0] xa = (va >> (k*w + (t ? n : 0))) & nmask;
      logic [VL-1:0] xb = (vb >> (k*w + (t ? n : 0))) & nmask;
      logic signed [67:0] sa = 68'(xa);
      logic signed [67:0] sb = 68'(xb);
      logic signed [67:0] d;
      logic [VL-1:0] r;
      if (!u && xa[n-1]) sa = sa - (68'sd1 <<< n);
      if (!u && xb[n-1]) sb = sb - (68'sd1 <<< n);
      d = sa - sb;
      if (d < 0) d = -d;
      r = (VL'(d) + ((vc >> (k*w)) & wmask)) & wmask;
      out = out | (r << (k*w));
    end
    return out;
  endfunction

  task automatic chk(bit ok, string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] w, logic [VL-1:0] va, vb, vc, string req);
    logic [VL-1:0] exp = model(w[11], w[10], w[23:22], va, vb, vc);
    @(negedge clk); insn = w; a = va; b = vb; c = vc; start = 1;
    @(negedge clk); start = 0;
    chk(valid === 1 && illegal === 0, {req, " R7 valid"}, VL'({valid, illegal}), VL'(2'b10));
    chk(result === exp, req, result, exp);
    a = ~va; c = ~vc;
    @(negedge clk);
    chk(valid === 0 && result === exp, "R8 hold", result, exp);
  endtask

  task automatic run_bad(logic [31:0] w, string req);
    logic [VL-1:0] prev = result;
    @(negedge clk); insn = w; a = {4{$urandom}}; start = 1;
    @(negedge clk); start = 0;
    chk(illegal === 1 && valid === 0, req, VL'({valid, illegal}), VL'(2'b01));
    chk(result === prev, {req, " result kept"}, result, prev);
  endtask

  function automatic logic [VL-1:0] fill(int w, logic [63:0] lane);
    logic [VL-1:0] v = '0;
    for (int k = 0; k < VL / w; k++) v = v | ((VL'(lane) & ((VL'(1) << w) - 1)) << (k*w));
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(result === 0 && valid === 0 && illegal === 0, "reset", result, 0);
    rst_n = 1;
    for (int s = 1; s < 4; s++)
      for (int v = 0; v < 4; v++)
        for (int i = 0; i < 12; i++)
          run(mk(v[1], v[0], 2'(s)), {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R2 R4 R5 R6 sweep");
    for (int s = 1; s < 4; s++)
      for (int t = 0; t < 2; t++) begin
        int w = 8 << s;
        int n = w / 2;
        logic [63:0] mn = 64'(1) << (n-1);
        logic [63:0] mx = mn - 1;
        int sh = t ? n : 0;
        run(mk(0, 1'(t), 2'(s)), fill(w, mn << sh), fill(w, mx << sh), '0, "R5 signed extreme");
        run(mk(0, 1'(t), 2'(s)), fill(w, mx << sh), fill(w, mn << sh), '1, "R6 extreme wrap");
        run(mk(1, 1'(t), 2'(s)), fill(w, 64'(5) << sh), fill(w, 64'(5) << sh), '1, "R6 equal acc max");
        run(mk(1, 1'(t), 2'(s)), fill(w, 64'(6) << sh), fill(w, 64'(5) << sh), '1, "R6 add wraps");
        run(mk(1, 1'(t), 2'(s)), fill(w, ~64'(0)), '0, '0, "R4 R5 unsigned both halves");
      end
    begin
      logic [VL-1:0] ra = {4{$urandom}}, rb = {4{$urandom}}, rc = {4{$urandom}};
      logic [31:0] w0 = mk(0, 1, 2'b10);
      logic [31:0] w1 = w0 ^ 32'h001F_03FF;
      run(w1, ra, rb, rc, "R9 register fields ignored");
    end
    run_bad({8'b01000101, 2'b00, 1'b0, 5'd3, 4'b1100, 2'b01, 10'd7}, "R3 reserved size");
    run_bad({8'b01000101, 2'b01, 1'b1, 5'd3, 4'b1100, 2'b01, 10'd7}, "R1 bit21 set");
    run_bad({8'b01000100, 2'b10, 1'b0, 5'd3, 4'b1100, 2'b00, 10'd7}, "R1 opcode mismatch");
    run_bad({8'b01000101, 2'b11, 1'b0, 5'd3, 4'b1101, 2'b10, 10'd7}, "R1 bits15_12 mismatch");
    @(negedge clk);
    chk(valid === 0 && illegal === 0, "R7 idle", VL'({valid, illegal}), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule